// File: doc/BRIEF.md
# Dispatch Group Slot Hazard Checker

This block models how an in-order front end packs instructions into dispatch groups of up to five slots. Every cycle a candidate instruction is presented as a small descriptor: a unit class and a handful of flags. These flags say whether the instruction must lead a group, fills a whole group, is split into two internal ops, stores to memory, writes the count register, or branches through the count register. From these and the current group state, the block returns a verdict in the same cycle. The verdict is one of three: issue freely, stall until a fresh group opens, or insert a no-op first.

When the scheduler issues the candidate, it pulses `issue_i`. The block then advances the slot count and records the count-register write and the store. A no-op strobe fills one slot, and a forced-end strobe abandons the current group. Pseudo and debug instructions use class 0, pass freely and never touch the state. The current slot count and the number of stores in the group are visible at the ports.

Top module: `dispatch_hazard_checker`

## Requirements
- R1: `verdict_o` encodes 0 = no hazard, 1 = stall, 2 = insert no-op. A candidate whose `unit_i` is 0 (pseudo or debug) always gets 0, and issuing it changes neither the slot count, the store count nor the count-register flag.
- R2: A non-pseudo candidate with `first_only_i` or `single_i` set gets verdict 1 whenever the slot count is not zero.
- R3: A cracked candidate gets verdict 1 when more than two slots are used. When it is issued, it adds two slots.
- R4: Classes 1 to 5 (fixed-point, load/store, floating-point, vector ALU, vector permute) get verdict 1 when four slots are used. Class 7 (branch) may still take the fifth slot.
- R5: Class 6 (condition register) gets verdict 1 when two or more slots are used.
- R6: A candidate with `ctr_branch_i` gets verdict 2 when an instruction issued earlier in the same group had `ctr_write_i`. When a stall condition also applies, verdict 1 wins.
- R7: Issuing a class 7 candidate, or one with `single_i`, closes the group, so the slot count reads 0 after the edge.
- R8: Each issued store raises `store_cnt_o` by one, saturating at four. When the slot count reaches five, the group ends. This clears the slot count, the store count and the count-register flag.
- R9: `noop_i` adds one slot when no non-pseudo issue happens in the same cycle; a non-pseudo issue takes precedence and the no-op is dropped. `noop_err_o` is high in the same cycle that `noop_i` arrives while four slots are already used.
- R10: `group_end_i` clears the whole group state at the next edge and overrides any issue or no-op in that cycle.
- R11: `rst_ni` low clears the slot count, the store count and the count-register flag asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| unit_i | input | 3 | Candidate unit class (0 pseudo, 1 fixed, 2 load/store, 3 float, 4 vector ALU, 5 vector permute, 6 cond reg, 7 branch) |
| first_only_i | input | 1 | Candidate must lead a group |
| single_i | input | 1 | Candidate fills a whole group |
| cracked_i | input | 1 | Candidate splits into two ops |
| store_i | input | 1 | Candidate writes memory |
| ctr_write_i | input | 1 | Candidate writes the count register |
| ctr_branch_i | input | 1 | Candidate branches through the count register |
| issue_i | input | 1 | Candidate issued this cycle |
| noop_i | input | 1 | A no-op is inserted this cycle |
| group_end_i | input | 1 | Force the current group to end |
| verdict_o | output | 2 | Hazard verdict for the candidate |
| noop_err_o | output | 1 | No-op inserted into a group with no non-branch slot left |
| slot_count_o | output | 3 | Slots used in the current group |
| store_cnt_o | output | 3 | Stores issued in the current group |

## Verification
`verdict_o` and `noop_err_o` are combinational: they are due in the same cycle the candidate and strobes are driven. `slot_count_o` and `store_cnt_o` change one rising edge after an issue, no-op or forced end. Reset is the exception, and it clears them at once. Each vector is therefore driven on a falling edge. The combinational verdict is sampled a few nanoseconds later, before the next rising edge. The registered counts are sampled a few nanoseconds after that rising edge, which is also the state the next vector's verdict is computed from.

// File: rtl/disp_pkg.sv
package disp_pkg;
  typedef enum logic [2:0] {
    UC_PSEUDO = 3'd0,
    UC_FIX    = 3'd1,
    UC_LDST   = 3'd2,
    UC_FLT    = 3'd3,
    UC_VALU   = 3'd4,
    UC_VPERM  = 3'd5,
    UC_COND   = 3'd6,
    UC_BRANCH = 3'd7
  } unit_e;

  typedef enum logic [1:0] {
    VD_NONE  = 2'd0,
    VD_STALL = 2'd1,
    VD_NOOP  = 2'd2
  } verdict_e;
endpackage

// File: rtl/disp_classify.sv
module disp_classify
  import disp_pkg::*;
(
  input  unit_e unit_i,
  input  logic  single_i,
  output logic  pseudo_o,
  output logic  branch_o,
  output logic  cond_o,
  output logic  non_branch_o,
  output logic  closes_o
);
  always_comb begin
    pseudo_o     = 1'b0;
    branch_o     = 1'b0;
    cond_o       = 1'b0;
    non_branch_o = 1'b0;
    unique case (unit_i)
      UC_PSEUDO: pseudo_o = 1'b1;
      UC_BRANCH: branch_o = 1'b1;
      UC_COND:   cond_o   = 1'b1;
      default:   non_branch_o = 1'b1;
    endcase
  end

  // branch or whole-group op pushes the group to its last slot
  assign closes_o = branch_o | single_i;
endmodule

// File: rtl/disp_stall_rules.sv
module disp_stall_rules #(
  parameter int MAX_SLOTS   = 5,
  parameter int CRACK_LIMIT = 2,
  parameter int COND_LIMIT  = 2,
  localparam int SW = $clog2(MAX_SLOTS)
) (
  input  logic [SW-1:0] slots_i,
  input  logic          pseudo_i,
  input  logic          cond_i,
  input  logic          non_branch_i,
  input  logic          first_only_i,
  input  logic          single_i,
  input  logic          cracked_i,
  output logic          stall_o
);
  localparam logic [SW-1:0] LastSlot = SW'(MAX_SLOTS - 1);
  localparam logic [SW-1:0] CrackLim = SW'(CRACK_LIMIT);
  localparam logic [SW-1:0] CondLim  = SW'(COND_LIMIT);

  logic lead_hit, crack_hit, last_hit, cond_hit;

  always_comb begin
    lead_hit  = (first_only_i | single_i) & (slots_i != '0);
    crack_hit = cracked_i & (slots_i > CrackLim);
    last_hit  = non_branch_i & (slots_i == LastSlot);
    cond_hit  = cond_i & (slots_i >= CondLim);
    stall_o   = ~pseudo_i & (lead_hit | crack_hit | last_hit | cond_hit);
  end
endmodule

// File: rtl/disp_group_state.sv
module disp_group_state #(
  parameter int MAX_SLOTS   = 5,
  parameter int STORE_DEPTH = 4,
  localparam int SW  = $clog2(MAX_SLOTS),
  localparam int STW = $clog2(STORE_DEPTH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           issue_live_i,
  input  logic           closes_i,
  input  logic           cracked_i,
  input  logic           store_i,
  input  logic           ctr_write_i,
  input  logic           noop_i,
  input  logic           group_end_i,
  output logic [SW-1:0]  slots_o,
  output logic [STW-1:0] store_cnt_o,
  output logic           ctr_set_o
);
  localparam logic [SW:0]  Full     = (SW+1)'(MAX_SLOTS);
  localparam logic [SW:0]  LastSlot = (SW+1)'(MAX_SLOTS - 1);
  localparam logic [STW-1:0] StMax  = STW'(STORE_DEPTH);

  logic [SW-1:0]  slots_q, slots_d;
  logic [STW-1:0] st_q, st_d;
  logic           ctr_q, ctr_d;
  logic [SW:0]    nxt;

  always_comb begin
    slots_d = slots_q;
    st_d    = st_q;
    ctr_d   = ctr_q;
    nxt     = {1'b0, slots_q};
    if (group_end_i) begin
      slots_d = '0;
      st_d    = '0;
      ctr_d   = 1'b0;
    end else if (issue_live_i) begin
      if (ctr_write_i) ctr_d = 1'b1;
      if (store_i && st_q < StMax) st_d = st_q + 1'b1;
      nxt = closes_i ? LastSlot : {1'b0, slots_q};
      nxt = nxt + 1'b1 + {{SW{1'b0}}, cracked_i};
      if (nxt >= Full) begin
        slots_d = '0;
        st_d    = '0;
        ctr_d   = 1'b0;
      end else begin
        slots_d = nxt[SW-1:0];
      end
    end else if (noop_i) begin
      nxt = {1'b0, slots_q} + 1'b1;
      if (nxt >= Full) begin
        slots_d = '0;
        st_d    = '0;
        ctr_d   = 1'b0;
      end else begin
        slots_d = nxt[SW-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slots_q <= '0;
      st_q    <= '0;
      ctr_q   <= 1'b0;
    end else begin
      slots_q <= slots_d;
      st_q    <= st_d;
      ctr_q   <= ctr_d;
    end
  end

  assign slots_o     = slots_q;
  assign store_cnt_o = st_q;
  assign ctr_set_o   = ctr_q;
endmodule

// File: rtl/dispatch_hazard_checker.sv
module dispatch_hazard_checker
  import disp_pkg::*;
#(
  parameter int MAX_SLOTS   = 5,
  parameter int STORE_DEPTH = 4,
  parameter int CRACK_LIMIT = 2,
  parameter int COND_LIMIT  = 2,
  localparam int SW  = $clog2(MAX_SLOTS),
  localparam int STW = $clog2(STORE_DEPTH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [2:0]     unit_i,
  input  logic           first_only_i,
  input  logic           single_i,
  input  logic           cracked_i,
  input  logic           store_i,
  input  logic           ctr_write_i,
  input  logic           ctr_branch_i,
  input  logic           issue_i,
  input  logic           noop_i,
  input  logic           group_end_i,
  output logic [1:0]     verdict_o,
  output logic           noop_err_o,
  output logic [SW-1:0]  slot_count_o,
  output logic [STW-1:0] store_cnt_o
);
  localparam logic [SW-1:0] LastSlot = SW'(MAX_SLOTS - 1);

  logic     pseudo, branch, cond, non_branch, closes;
  logic     stall, ctr_set;
  verdict_e verdict;

  disp_classify u_classify (
    .unit_i       (unit_e'(unit_i)),
    .single_i     (single_i),
    .pseudo_o     (pseudo),
    .branch_o     (branch),
    .cond_o       (cond),
    .non_branch_o (non_branch),
    .closes_o     (closes)
  );

  disp_stall_rules #(
    .MAX_SLOTS   (MAX_SLOTS),
    .CRACK_LIMIT (CRACK_LIMIT),
    .COND_LIMIT  (COND_LIMIT)
  ) u_rules (
    .slots_i      (slot_count_o),
    .pseudo_i     (pseudo),
    .cond_i       (cond),
    .non_branch_i (non_branch),
    .first_only_i (first_only_i),
    .single_i     (single_i),
    .cracked_i    (cracked_i),
    .stall_o      (stall)
  );

  disp_group_state #(
    .MAX_SLOTS   (MAX_SLOTS),
    .STORE_DEPTH (STORE_DEPTH)
  ) u_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .issue_live_i (issue_i & ~pseudo),
    .closes_i     (closes),
    .cracked_i    (cracked_i),
    .store_i      (store_i),
    .ctr_write_i  (ctr_write_i),
    .noop_i       (noop_i),
    .group_end_i  (group_end_i),
    .slots_o      (slot_count_o),
    .store_cnt_o  (store_cnt_o),
    .ctr_set_o    (ctr_set)
  );

  // stall checks outrank the no-op check
  always_comb begin
    if (pseudo)                        verdict = VD_NONE;
    else if (stall)                    verdict = VD_STALL;
    else if (ctr_branch_i && ctr_set)  verdict = VD_NOOP;
    else                               verdict = VD_NONE;
  end

  assign verdict_o  = verdict;
  assign noop_err_o = noop_i & (slot_count_o == LastSlot);

  logic unused_branch;
  assign unused_branch = branch;
endmodule

// File: rtl/disp_checker.sv
module disp_checker #(
  parameter int MAX_SLOTS = 5,
  parameter int SW  = 3,
  parameter int STW = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [2:0]     unit_i,
  input logic           first_only_i,
  input logic           issue_i,
  input logic           noop_i,
  input logic           group_end_i,
  input logic [1:0]     verdict_o,
  input logic [SW-1:0]  slot_count_o,
  input logic [STW-1:0] store_cnt_o
);
  assert_verdict_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_o != 2'd3);

  assert_pseudo_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && unit_i == 3'd0 && !noop_i && !group_end_i)
    |=> ($stable(slot_count_o) && $stable(store_cnt_o)));

  assert_lead_stall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit_i != 3'd0 && first_only_i && slot_count_o != '0) |-> verdict_o == 2'd1);

  assert_branch_close_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && unit_i == 3'd7 && !group_end_i) |=> slot_count_o == '0);

  assert_slot_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(slot_count_o) < MAX_SLOTS);

  assert_noop_fill_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (noop_i && !issue_i && !group_end_i && int'(slot_count_o) == MAX_SLOTS - 1)
    |=> slot_count_o == '0);

  assert_force_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    group_end_i |=> (slot_count_o == '0 && store_cnt_o == '0));
endmodule

bind dispatch_hazard_checker disp_checker #(
  .MAX_SLOTS (MAX_SLOTS),
  .SW        (SW),
  .STW       (STW)
) i_disp_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .unit_i       (unit_i),
  .first_only_i (first_only_i),
  .issue_i      (issue_i),
  .noop_i       (noop_i),
  .group_end_i  (group_end_i),
  .verdict_o    (verdict_o),
  .slot_count_o (slot_count_o),
  .store_cnt_o  (store_cnt_o)
);

// File: tb/test_dispatch_hazard_checker.sv
module test_dispatch_hazard_checker;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] unit_i = '0;
  logic first_only_i = 0, single_i = 0, cracked_i = 0, store_i = 0;
  logic ctr_write_i = 0, ctr_branch_i = 0, issue_i = 0, noop_i = 0, group_end_i = 0;
  logic [1:0] verdict_o;
  logic noop_err_o;
  logic [2:0] slot_count_o, store_cnt_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dispatch_hazard_checker i_dispatch_hazard_checker (
    .clk_i(clk), .rst_ni(rst_ni), .unit_i(unit_i), .first_only_i(first_only_i),
    .single_i(single_i), .cracked_i(cracked_i), .store_i(store_i),
    .ctr_write_i(ctr_write_i), .ctr_branch_i(ctr_branch_i), .issue_i(issue_i),
    .noop_i(noop_i), .group_end_i(group_end_i), .verdict_o(verdict_o),
    .noop_err_o(noop_err_o), .slot_count_o(slot_count_o), .store_cnt_o(store_cnt_o)
  );

  typedef struct packed {
    logic [2:0] unit;
    logic fo, sg, cr, st, cw, cb, iss, nop, gend;
    logic [1:0] v;
    logic err;
    logic [2:0] slots;
    logic [2:0] stc;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 27;
  // unit fo sg cr st cw cb iss nop gend | verdict err slots_after stores_after req
  localparam vec_t VEC [NV] = '{
    '{3'd1,0,0,0,0,0,0,1,0,0, 2'd0,0,3'd1,3'd0,4'd4},  // R4 fixed issue
    '{3'd1,1,0,0,0,0,0,0,0,0, 2'd1,0,3'd1,3'd0,4'd2},  // R2 first-only late
    '{3'd6,0,0,0,0,0,0,1,0,0, 2'd0,0,3'd2,3'd0,4'd5},  // R5 cond at 1
    '{3'd6,0,0,0,0,0,0,0,0,0, 2'd1,0,3'd2,3'd0,4'd5},  // R5 cond at 2
    '{3'd2,0,0,0,1,0,0,1,0,0, 2'd0,0,3'd3,3'd1,4'd8},  // R8 store counted
    '{3'd3,0,0,1,0,0,0,0,0,0, 2'd1,0,3'd3,3'd1,4'd3},  // R3 cracked at 3
    '{3'd4,0,0,0,0,0,0,1,0,0, 2'd0,0,3'd4,3'd1,4'd4},
    '{3'd5,0,0,0,0,0,0,0,0,0, 2'd1,0,3'd4,3'd1,4'd4},  // R4 non-branch at 4
    '{3'd0,0,0,0,0,0,0,0,1,0, 2'd0,1,3'd0,3'd0,4'd9},  // R9 noop fills, err
    '{3'd1,0,0,0,0,1,0,1,0,0, 2'd0,0,3'd1,3'd0,4'd6},  // R6 ctr write
    '{3'd7,0,0,0,0,0,1,0,0,0, 2'd2,0,3'd1,3'd0,4'd6},  // R6 noop verdict
    '{3'd7,1,0,0,0,0,1,0,0,0, 2'd1,0,3'd1,3'd0,4'd6},  // R6 stall wins
    '{3'd7,0,0,0,0,0,0,1,0,0, 2'd0,0,3'd0,3'd0,4'd7},  // R7 branch closes
    '{3'd7,0,0,0,0,0,1,0,0,0, 2'd0,0,3'd0,3'd0,4'd8},  // R8 ctr flag cleared
    '{3'd1,0,0,1,0,0,0,1,0,0, 2'd0,0,3'd2,3'd0,4'd3},  // R3 cracked adds two
    '{3'd0,0,1,0,1,1,0,1,0,0, 2'd0,0,3'd2,3'd0,4'd1},  // R1 pseudo ignored
    '{3'd7,0,0,0,0,0,1,0,0,0, 2'd0,0,3'd2,3'd0,4'd1},  // R1 ctr not set by pseudo
    '{3'd0,0,0,0,0,0,0,0,1,0, 2'd0,0,3'd3,3'd0,4'd9},  // R9 noop adds one
    '{3'd1,0,0,0,1,0,0,1,0,1, 2'd0,0,3'd0,3'd0,4'd10}, // R10 forced end wins
    '{3'd1,0,1,0,0,0,0,1,0,0, 2'd0,0,3'd0,3'd0,4'd7},  // R7 single closes
    '{3'd1,0,0,0,0,0,0,1,1,0, 2'd0,0,3'd1,3'd0,4'd9},  // R9 issue beats noop
    '{3'd1,0,0,0,1,0,0,1,0,0, 2'd0,0,3'd2,3'd1,4'd8},
    '{3'd2,0,0,1,1,0,0,1,0,0, 2'd0,0,3'd4,3'd2,4'd3},  // R3 cracked at 2 ok
    '{3'd7,0,0,0,0,0,0,0,0,0, 2'd0,0,3'd4,3'd2,4'd4},  // R4 branch at 4 ok
    '{3'd6,0,0,0,0,0,0,0,0,0, 2'd1,0,3'd4,3'd2,4'd5},  // R5 cond at 4
    '{3'd0,1,0,0,0,0,0,0,0,0, 2'd0,0,3'd4,3'd2,4'd1},  // R1 pseudo never stalls
    '{3'd7,0,0,0,0,0,0,1,0,0, 2'd0,0,3'd0,3'd0,4'd8}   // R8 fifth slot ends group
  };

  task automatic chk(input int req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive_idle();
    unit_i = '0; first_only_i = 0; single_i = 0; cracked_i = 0; store_i = 0;
    ctr_write_i = 0; ctr_branch_i = 0; issue_i = 0; noop_i = 0; group_end_i = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    drive_idle();
    repeat (3) @(posedge clk);
    #2;
    // R11 reset state
    chk(11, "reset slots", int'(slot_count_o), 0);
    chk(11, "reset stores", int'(store_cnt_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    unit_i = 3'd1; first_only_i = 1;
    #2;
    chk(11, "reset verdict first-only", int'(verdict_o), 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      unit_i = VEC[i].unit; first_only_i = VEC[i].fo; single_i = VEC[i].sg;
      cracked_i = VEC[i].cr; store_i = VEC[i].st; ctr_write_i = VEC[i].cw;
      ctr_branch_i = VEC[i].cb; issue_i = VEC[i].iss; noop_i = VEC[i].nop;
      group_end_i = VEC[i].gend;
      #2;
      chk(int'(VEC[i].req), $sformatf("vec%0d verdict", i), int'(verdict_o), int'(VEC[i].v));
      chk(9, $sformatf("vec%0d noop_err", i), int'(noop_err_o), int'(VEC[i].err));
      @(posedge clk);
      #2;
      chk(int'(VEC[i].req), $sformatf("vec%0d slots", i), int'(slot_count_o), int'(VEC[i].slots));
      chk(int'(VEC[i].req), $sformatf("vec%0d stores", i), int'(store_cnt_o), int'(VEC[i].stc));
    end

    // R8 store count saturation boundary: four stores in one group
    @(negedge clk);
    drive_idle();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      unit_i = 3'd2; store_i = 1; issue_i = 1;
      @(posedge clk);
      #2;
    end
    chk(8, "four stores", int'(store_cnt_o), 4);
    chk(8, "four slots", int'(slot_count_o), 4);

    // R11 asynchronous reset mid-group
    @(negedge clk);
    drive_idle();
    rst_ni = 1'b0;
    #2;
    chk(11, "async reset slots", int'(slot_count_o), 0);
    chk(11, "async reset stores", int'(store_cnt_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule